// File: doc/BRIEF.md
# Four-channel DMA controller register interface

This block is the processor-side register file of a four-channel DMA controller. A processor reaches it through a chip select, active-low read and write strobes, a four-bit register address and an eight-bit data bus. When address bit 3 is high, the low three address bits pick a register. The same code can mean different things for a read and for a write. Several writes are software commands rather than stores: master clear, setting the byte pointer, and clearing the mode sequencing counter.

The block holds the command byte, the sticky end-of-transfer flags, the latched request levels, the temporary byte of memory-to-memory transfers, the four channel masks, the software request bits, one mode field per channel with its read sequencing counter, and the byte-pointer flag. It presents the command byte, masks, software requests, mode fields, byte pointer and a one-cycle master-clear pulse to the channel and timing logic. That logic in turn supplies terminal-count and end-of-process hits, raw channel request levels and the temporary byte to load.

Top module: `dma_regif`

## Requirements
- R1: After a synchronous reset, cmd_o is 0x00, mask_o is 0xF, swreq_o is 0x0, bptr_o is 0, mclr_o is 0, dout is 0x00, and both a status read and a temporary read return 0x00.
- R2: A register access occurs only in the cycle in which rd_n or wr_n is first seen low while cs_n is low. Holding a strobe low does not repeat the access. A strobe with cs_n high, or any access with addr[3]=0, changes no register. A read with addr[3]=0 returns 0x00. dout changes only on a read access.
- R3: A write to address 0x8 loads the command byte, which appears on cmd_o in the next cycle. A read of address 0xA returns it. Bit 6 of the command byte inverts the sense of req_in.
- R4: Status bits 3:0 are per-channel sticky flags. A flag is set by tc_hit or eop_hit for its channel. A read of address 0x8 returns the flags, and they are cleared after that read. A hit that arrives in the same cycle as the status read stays set.
- R5: Status bits 7:4 show the request level of channels 3..0, sampled on the falling clock edge. They do not depend on the mask bits. When command bit 6 is set, a low req_in counts as a request.
- R6: A write to address 0xA sets mask bit din[1:0] to the value of din[2]. A write to address 0xF loads all four mask bits from din[3:0]. A read of address 0xF returns {4'b0000, mask}.
- R7: A write to address 0x9 sets software request bit din[1:0] to the value of din[2]. A read of address 0x9 returns {4'b0000, swreq}.
- R8: A write to address 0xB stores din[7:2] as the mode field of channel din[1:0]. A read of address 0xB returns {mode field of channel n, n}, where n is the sequencing counter; the read then advances the counter modulo 4. A write to address 0xE clears the counter. mode_o carries channel c in bits 6c+5:6c.
- R9: A write to address 0xC sets bptr_o in the next cycle.
- R10: tmp_ld loads tmp_data into the temporary register. A read of address 0xD returns it. The value is kept until the next load, reset or master clear.
- R11: A write to address 0xD is a master clear. In the next cycle mclr_o is high for exactly one cycle, cmd_o is 0, mask_o is 0xF, swreq_o is 0, bptr_o is 0, and the mode counter, temporary register and status flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 4 | Register address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, registered at the read access |
| tc_hit | input | 4 | Terminal-count hit per channel |
| eop_hit | input | 4 | External end-of-process hit per channel |
| req_in | input | 4 | Raw channel request levels |
| tmp_ld | input | 1 | Load strobe for the temporary register |
| tmp_data | input | 8 | Byte moved by a memory-to-memory transfer |
| cmd_o | output | 8 | Command byte |
| mask_o | output | 4 | Channel mask bits |
| swreq_o | output | 4 | Software request bits |
| mode_o | output | 24 | Mode fields, six bits per channel |
| bptr_o | output | 1 | Byte-pointer flag |
| mclr_o | output | 1 | One-cycle master-clear pulse |

## Verification
The status read and a terminal-count or end-of-process hit can fall in the same clock cycle. In that cycle the read-clear and the flag set compete for the same bit. The bench pulses tc_hit in exactly the cycle of the read strobe's first low sample. It expects the returned byte to lack the new flag, and the next status read to show it. A second overlap, a mode read while the read strobe is held low for several cycles, checks that the sequencing counter advances only once.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;
    localparam int NCH   = 4;
    localparam int CHW   = $clog2(NCH);
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int MODEW = DW - CHW;

    typedef enum logic [2:0] {
        SEL_STAT_CMD  = 3'd0,
        SEL_SWREQ     = 3'd1,
        SEL_CMD_SMASK = 3'd2,
        SEL_MODE      = 3'd3,
        SEL_BPTR      = 3'd4,
        SEL_TMP_MCLR  = 3'd5,
        SEL_MCNT      = 3'd6,
        SEL_AMASK     = 3'd7
    } sel_e;

    typedef struct packed {
        logic cmd_wr;
        logic sreq_wr;
        logic smask_wr;
        logic mode_wr;
        logic bptr_set;
        logic mclr;
        logic mcnt_clr;
        logic amask_wr;
    } wr_cmd_t;

    typedef struct packed {
        logic stat_rd;
        logic sreq_rd;
        logic cmd_rd;
        logic mode_rd;
        logic tmp_rd;
        logic amask_rd;
    } rd_cmd_t;

    function automatic logic [NCH-1:0] set_one_bit(
        input logic [NCH-1:0] cur, input logic [CHW-1:0] ch, input logic val);
        logic [NCH-1:0] r;
        r = cur;
        r[ch] = val;
        return r;
    endfunction
endpackage

// File: rtl/dma_regif_decode.sv
module dma_regif_decode
    import dma_regif_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    output logic          rd_go,
    output logic          wr_go,
    output wr_cmd_t       wcmd,
    output rd_cmd_t       rcmd
);
    logic rd_q, wr_q;
    sel_e sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b1;
            wr_q <= 1'b1;
        end else begin
            rd_q <= rd_n;
            wr_q <= wr_n;
        end
    end

    assign rd_go = !cs_n && !rd_n && rd_q;
    assign wr_go = !cs_n && !wr_n && wr_q;
    assign sel   = sel_e'(addr[AW-2:0]);

    always_comb begin
        wcmd = '0;
        rcmd = '0;
        if (wr_go && addr[AW-1]) begin
            unique case (sel)
                SEL_STAT_CMD:  wcmd.cmd_wr   = 1'b1;
                SEL_SWREQ:     wcmd.sreq_wr  = 1'b1;
                SEL_CMD_SMASK: wcmd.smask_wr = 1'b1;
                SEL_MODE:      wcmd.mode_wr  = 1'b1;
                SEL_BPTR:      wcmd.bptr_set = 1'b1;
                SEL_TMP_MCLR:  wcmd.mclr     = 1'b1;
                SEL_MCNT:      wcmd.mcnt_clr = 1'b1;
                SEL_AMASK:     wcmd.amask_wr = 1'b1;
                default: ;
            endcase
        end
        if (rd_go && addr[AW-1]) begin
            unique case (sel)
                SEL_STAT_CMD:  rcmd.stat_rd  = 1'b1;
                SEL_SWREQ:     rcmd.sreq_rd  = 1'b1;
                SEL_CMD_SMASK: rcmd.cmd_rd   = 1'b1;
                SEL_MODE:      rcmd.mode_rd  = 1'b1;
                SEL_TMP_MCLR:  rcmd.tmp_rd   = 1'b1;
                SEL_AMASK:     rcmd.amask_rd = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dma_regif_status.sv
module dma_regif_status
    import dma_regif_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           mclr_now,
    input  logic           mclr_pulse,
    input  logic           stat_rd,
    input  logic           req_low_active,
    input  logic [NCH-1:0] tc_hit,
    input  logic [NCH-1:0] eop_hit,
    input  logic [NCH-1:0] req_in,
    output logic [NCH-1:0] tc_flags,
    output logic [NCH-1:0] req_flags
);
    // Sticky flags: a same-cycle hit wins over the read-clear.
    always_ff @(posedge clk) begin
        if (rst || mclr_now)
            tc_flags <= '0;
        else
            tc_flags <= (stat_rd ? '0 : tc_flags) | tc_hit | eop_hit;
    end

    // Request levels captured on the falling edge.
    always_ff @(negedge clk) begin
        if (rst || mclr_pulse)
            req_flags <= '0;
        else
            req_flags <= req_in ^ {NCH{req_low_active}};
    end
endmodule

// File: rtl/dma_regif_chan.sv
module dma_regif_chan
    import dma_regif_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_cmd_t            wcmd,
    input  logic               mode_rd,
    input  logic [DW-1:0]      din,
    output logic [NCH-1:0]     mask,
    output logic [NCH-1:0]     swreq,
    output logic [NCH*MODEW-1:0] mode_flat,
    output logic [CHW-1:0]     mcnt,
    output logic [MODEW-1:0]   mode_sel
);
    logic [CHW-1:0]   ch;
    logic [MODEW-1:0] mode_r [NCH];

    assign ch = din[CHW-1:0];

    always_ff @(posedge clk) begin
        if (rst || wcmd.mclr) begin
            mask  <= '1;
            swreq <= '0;
        end else begin
            if (wcmd.smask_wr)
                mask <= set_one_bit(mask, ch, din[CHW]);
            else if (wcmd.amask_wr)
                mask <= din[NCH-1:0];
            if (wcmd.sreq_wr)
                swreq <= set_one_bit(swreq, ch, din[CHW]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || wcmd.mclr || wcmd.mcnt_clr)
            mcnt <= '0;
        else if (mode_rd)
            mcnt <= mcnt + 1'b1;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (rst)
                mode_r[g] <= '0;
            else if (wcmd.mode_wr && ch == CHW'(g))
                mode_r[g] <= din[DW-1:CHW];
        end
        assign mode_flat[g*MODEW +: MODEW] = mode_r[g];
    end

    assign mode_sel = mode_r[mcnt];
endmodule

// File: rtl/dma_regif.sv
module dma_regif
    import dma_regif_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        din,
    output logic [DW-1:0]        dout,
    input  logic [NCH-1:0]       tc_hit,
    input  logic [NCH-1:0]       eop_hit,
    input  logic [NCH-1:0]       req_in,
    input  logic                 tmp_ld,
    input  logic [DW-1:0]        tmp_data,
    output logic [DW-1:0]        cmd_o,
    output logic [NCH-1:0]       mask_o,
    output logic [NCH-1:0]       swreq_o,
    output logic [NCH*MODEW-1:0] mode_o,
    output logic                 bptr_o,
    output logic                 mclr_o
);
    localparam int REQ_SENSE_BIT = 6;

    logic             rd_go, wr_go;
    wr_cmd_t          wcmd;
    rd_cmd_t          rcmd;
    logic [NCH-1:0]   tc_flags, req_flags;
    logic [CHW-1:0]   mcnt;
    logic [MODEW-1:0] mode_sel;
    logic [DW-1:0]    tmp_q, rd_mux;

    dma_regif_decode u_dec (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .rd_go(rd_go), .wr_go(wr_go), .wcmd(wcmd), .rcmd(rcmd)
    );

    dma_regif_status u_stat (
        .clk(clk), .rst(rst), .mclr_now(wcmd.mclr), .mclr_pulse(mclr_o),
        .stat_rd(rcmd.stat_rd), .req_low_active(cmd_o[REQ_SENSE_BIT]),
        .tc_hit(tc_hit), .eop_hit(eop_hit), .req_in(req_in),
        .tc_flags(tc_flags), .req_flags(req_flags)
    );

    dma_regif_chan u_chan (
        .clk(clk), .rst(rst), .wcmd(wcmd), .mode_rd(rcmd.mode_rd), .din(din),
        .mask(mask_o), .swreq(swreq_o), .mode_flat(mode_o),
        .mcnt(mcnt), .mode_sel(mode_sel)
    );

    always_ff @(posedge clk) begin
        if (rst || wcmd.mclr) begin
            cmd_o  <= '0;
            tmp_q  <= '0;
            bptr_o <= 1'b0;
        end else begin
            if (wcmd.cmd_wr)   cmd_o  <= din;
            if (tmp_ld)        tmp_q  <= tmp_data;
            if (wcmd.bptr_set) bptr_o <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mclr_o <= 1'b0;
        else     mclr_o <= wcmd.mclr;
    end

    always_comb begin
        rd_mux = '0;
        if (rcmd.stat_rd)  rd_mux = {req_flags, tc_flags};
        if (rcmd.sreq_rd)  rd_mux = {{(DW-NCH){1'b0}}, swreq_o};
        if (rcmd.cmd_rd)   rd_mux = cmd_o;
        if (rcmd.mode_rd)  rd_mux = {mode_sel, mcnt};
        if (rcmd.tmp_rd)   rd_mux = tmp_q;
        if (rcmd.amask_rd) rd_mux = {{(DW-NCH){1'b0}}, mask_o};
    end

    always_ff @(posedge clk) begin
        if (rst)        dout <= '0;
        else if (rd_go) dout <= rd_mux;
    end
endmodule

// File: rtl/dma_regif_chk.sv
module dma_regif_chk
    import dma_regif_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           rd_go,
    input wr_cmd_t        wcmd,
    input rd_cmd_t        rcmd,
    input logic [DW-1:0]  din,
    input logic [DW-1:0]  dout,
    input logic [DW-1:0]  cmd_o,
    input logic [NCH-1:0] mask_o,
    input logic [NCH-1:0] swreq_o,
    input logic           bptr_o,
    input logic           mclr_o,
    input logic [NCH-1:0] tc_hit,
    input logic [NCH-1:0] eop_hit,
    input logic [NCH-1:0] tc_flags
);
    AST_CMD_LOAD: assert property (@(posedge clk) disable iff (rst)
        wcmd.cmd_wr |=> cmd_o == $past(din)); // R3

    AST_MCLR_STATE: assert property (@(posedge clk) disable iff (rst)
        mclr_o |-> (cmd_o == '0 && mask_o == '1 && swreq_o == '0 && !bptr_o)); // R11

    AST_MCLR_ONESHOT: assert property (@(posedge clk) disable iff (rst)
        mclr_o |=> !mclr_o); // R11

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        ((tc_hit | eop_hit) != '0 && !wcmd.mclr)
        |=> (tc_flags & $past(tc_hit | eop_hit)) == $past(tc_hit | eop_hit)); // R4

    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!rcmd.stat_rd && !wcmd.mclr)
        |=> (tc_flags & $past(tc_flags)) == $past(tc_flags)); // R4

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(dout)); // R2

    AST_ACCESS_ONCE: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> !rd_go); // R2

    AST_BPTR_SET: assert property (@(posedge clk) disable iff (rst)
        wcmd.bptr_set |=> bptr_o); // R9
endmodule

bind dma_regif dma_regif_chk u_chk (
    .clk(clk), .rst(rst), .rd_go(rd_go), .wcmd(wcmd), .rcmd(rcmd),
    .din(din), .dout(dout), .cmd_o(cmd_o), .mask_o(mask_o),
    .swreq_o(swreq_o), .bptr_o(bptr_o), .mclr_o(mclr_o),
    .tc_hit(tc_hit), .eop_hit(eop_hit), .tc_flags(tc_flags)
);

// File: tb/tb_dma_regif.sv
`timescale 1ns/1ps
module tb_dma_regif;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic [3:0]  tc_hit = '0, eop_hit = '0, req_in = '0;
    logic        tmp_ld = 1'b0;
    logic [7:0]  tmp_data = '0;
    logic [7:0]  cmd_o;
    logic [3:0]  mask_o, swreq_o;
    logic [23:0] mode_o;
    logic        bptr_o, mclr_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] v;

    always #2 clk = ~clk;

    dma_regif dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .tc_hit(tc_hit),
        .eop_hit(eop_hit), .req_in(req_in), .tmp_ld(tmp_ld),
        .tmp_data(tmp_data), .cmd_o(cmd_o), .mask_o(mask_o),
        .swreq_o(swreq_o), .mode_o(mode_o), .bptr_o(bptr_o), .mclr_o(mclr_o)
    );

    typedef struct packed {
        logic       is_wr;
        logic [3:0] a;
        logic [7:0] d;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'h8, 8'h55, 8'h00},  // R3 command load
        '{1'b0, 4'hA, 8'h00, 8'h55},  // R3 command read
        '{1'b1, 4'hF, 8'h05, 8'h00},  // R6 all masks
        '{1'b0, 4'hF, 8'h00, 8'h05},  // R6
        '{1'b1, 4'hA, 8'h05, 8'h00},  // R6 set ch1
        '{1'b0, 4'hF, 8'h00, 8'h07},  // R6
        '{1'b1, 4'hA, 8'h00, 8'h00},  // R6 clear ch0
        '{1'b0, 4'hF, 8'h00, 8'h06},  // R6
        '{1'b1, 4'h9, 8'h07, 8'h00},  // R7 set ch3
        '{1'b1, 4'h9, 8'h04, 8'h00},  // R7 set ch0
        '{1'b0, 4'h9, 8'h00, 8'h09},  // R7
        '{1'b1, 4'h9, 8'h03, 8'h00},  // R7 clear ch3
        '{1'b0, 4'h9, 8'h00, 8'h01},  // R7
        '{1'b1, 4'hB, 8'hA1, 8'h00},  // R8 ch1 mode 0x28
        '{1'b1, 4'hB, 8'hFC, 8'h00},  // R8 ch0 mode 0x3F
        '{1'b1, 4'hE, 8'h00, 8'h00},  // R8 counter clear
        '{1'b0, 4'hB, 8'h00, 8'hFC},  // R8 counter 0
        '{1'b0, 4'hB, 8'h00, 8'hA1}   // R8 counter 1
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        tick();
        cs_n = 1'b0; addr = a; din = d; wr_n = 1'b0;
        tick();
        wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        tick();
        cs_n = 1'b0; addr = a; rd_n = 1'b0;
        tick();
        d = dout;
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk("R1 cmd", cmd_o, 8'h00);
        chk("R1 mask", mask_o, 4'hF);
        chk("R1 swreq", swreq_o, 4'h0);
        chk("R1 bptr", bptr_o, 1'b0);
        chk("R1 mclr", mclr_o, 1'b0);
        chk("R1 dout", dout, 8'h00);
        bus_rd(4'h8, v); chk("R1 status", v, 8'h00);
        bus_rd(4'hD, v); chk("R1 temp", v, 8'h00);

        // Table walk: R3 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) bus_wr(VEC[i].a, VEC[i].d);
            else begin
                bus_rd(VEC[i].a, v);
                chk($sformatf("table[%0d] R3/R6/R7/R8", i), v, VEC[i].exp);
            end
        end
        chk("R6 mask port", mask_o, 4'h6);
        chk("R7 swreq port", swreq_o, 4'h1);
        chk("R8 mode port", mode_o, {6'h00, 6'h00, 6'h28, 6'h3F});
        bus_rd(4'hB, v); chk("R8 counter 2", v, 8'h02);
        bus_rd(4'hB, v); chk("R8 counter 3", v, 8'h03);
        bus_rd(4'hB, v); chk("R8 wrap", v, 8'hFC);

        // R2 held read strobe advances the counter once
        bus_wr(4'hE, 8'h00);
        tick();
        cs_n = 1'b0; addr = 4'hB; rd_n = 1'b0;
        repeat (3) tick();
        chk("R2 held read data", dout, 8'hFC);
        rd_n = 1'b1; cs_n = 1'b1;
        bus_rd(4'hB, v); chk("R2 single advance", v, 8'hA1);

        // R2 no access without chip select or with addr[3] low
        bus_wr(4'h8, 8'h00);
        tick();
        cs_n = 1'b1; addr = 4'h8; din = 8'hFF; wr_n = 1'b0;
        tick(); tick();
        wr_n = 1'b1;
        chk("R2 cs high", cmd_o, 8'h00);
        bus_wr(4'h7, 8'h0F);
        chk("R2 addr3 low mask", mask_o, 4'h6);
        chk("R2 addr3 low cmd", cmd_o, 8'h00);
        bus_rd(4'h0, v); chk("R2 addr3 low read", v, 8'h00);

        // R4 sticky flags
        tick(); tc_hit = 4'b0010; tick(); tc_hit = 4'b0000;
        bus_rd(4'h8, v); chk("R4 tc flag", v, 8'h02);
        bus_rd(4'h8, v); chk("R4 cleared", v, 8'h00);
        tick(); eop_hit = 4'b1000; tick(); eop_hit = 4'b0000;
        bus_rd(4'h8, v); chk("R4 eop flag", v, 8'h08);
        // R4 hit in the same cycle as the status read
        tick();
        cs_n = 1'b0; addr = 4'h8; rd_n = 1'b0; tc_hit = 4'b0100;
        tick();
        v = dout;
        rd_n = 1'b1; cs_n = 1'b1; tc_hit = 4'b0000;
        chk("R4 concurrent read data", v, 8'h00);
        bus_rd(4'h8, v); chk("R4 concurrent hit kept", v, 8'h04);

        // R5 request levels, independent of masks, sense from command bit 6
        bus_wr(4'hF, 8'h0F);
        tick(); req_in = 4'b0101; tick();
        bus_rd(4'h8, v); chk("R5 active high", v, 8'h50);
        bus_wr(4'h8, 8'h40);
        tick();
        bus_rd(4'h8, v); chk("R5 active low", v, 8'hA0);
        bus_wr(4'h8, 8'h00);
        req_in = 4'b0000;

        // R9 byte pointer
        chk("R9 before", bptr_o, 1'b0);
        bus_wr(4'hC, 8'h00);
        chk("R9 set", bptr_o, 1'b1);

        // R10 temporary register
        tick(); tmp_ld = 1'b1; tmp_data = 8'h3C; tick(); tmp_ld = 1'b0;
        bus_rd(4'hD, v); chk("R10 temp", v, 8'h3C);
        bus_wr(4'h8, 8'h11);
        bus_rd(4'hD, v); chk("R10 temp held", v, 8'h3C);

        // R11 master clear
        bus_wr(4'h9, 8'h06);
        bus_wr(4'hF, 8'h00);
        tick(); tc_hit = 4'b0001; tick(); tc_hit = 4'b0000;
        bus_rd(4'hB, v);
        bus_wr(4'hD, 8'h00);
        chk("R11 pulse", mclr_o, 1'b1);
        chk("R11 cmd", cmd_o, 8'h00);
        chk("R11 mask", mask_o, 4'hF);
        chk("R11 swreq", swreq_o, 4'h0);
        chk("R11 bptr", bptr_o, 1'b0);
        tick();
        chk("R11 pulse one cycle", mclr_o, 1'b0);
        bus_rd(4'hD, v); chk("R11 temp", v, 8'h00);
        bus_rd(4'h8, v); chk("R11 status", v, 8'h00);
        bus_rd(4'hB, v); chk("R11 counter", v, 8'hFC);

        finish_run();
    end
endmodule